// File: doc/BRIEF.md
# Indexed Indirect Address Resolver

This block turns a 36-bit instruction word into its 18-bit effective address. When an instruction is accepted, its operation and accumulator fields are captured. The block then works through the rest of the word. A nonzero index field adds the low 18 bits of the selected general register to the address field. A set indirect flag makes the block read another word from the address just formed. That word supplies fresh indirect, index and address fields, and the walk continues until a word arrives with its indirect flag clear.

Addresses below 16 name the general registers, so an indirect step that lands there reads the register file and not memory. The register file has one combinational read port. Memory is reached through a request/valid read port, with one transaction for each indirect level. The result leaves on a one-cycle `done_o` pulse. It carries the effective address and a rewritten word that holds the original operation and accumulator, a zero indirect/index area and the final address. A depth limit (`MAX_DEPTH` fetches) ends a runaway chain with an `err_o` pulse in place of `done_o`.

The controller has six states:
- `S_IDLE`: waiting. `start_i` moves it to `S_CALC`.
- `S_CALC`: forms the address. It goes to `S_DONE` when the current indirect flag is clear. It goes to `S_FAULT` when the flag is set and `MAX_DEPTH` fetches are used up. Otherwise it goes to `S_REGRD` for an address below 16 and to `S_MEMRD` for any other address.
- `S_REGRD`: loads the next fields from a register and returns to `S_CALC`.
- `S_MEMRD`: holds the memory request until `mem_valid_i`, then returns to `S_CALC`.
- `S_DONE` and `S_FAULT`: each lasts one cycle and returns to `S_IDLE`.

Top module: `ea_resolver`

## Requirements
- R1: Fields, with bit 35 as the leftmost bit: operation [35:27], accumulator [26:23], indirect flag [22], index [21:18], address [17:0].
- R2: With index zero and indirect clear, the effective address equals the address field.
- R3: With a nonzero index, the effective address is the address field plus bits [17:0] of the selected register, truncated to 18 bits (wrap-around discards the carry).
- R4: An index of zero never adds register 0, whatever register 0 holds.
- R5: While the current indirect flag is set, the word at the current effective address is read and its indirect, index and address fields replace the current ones. Indexing is applied again at every level.
- R6: An indirect step to an address below 16 reads register (address[3:0]) and issues no memory request.
- R7: On `done_o`, `word_o` is {original bits [35:23], five zero bits, effective address} and `ea_o` holds the effective address.
- R8: Operation and accumulator bits of fetched words are ignored. The output keeps those of the accepted instruction.
- R9: Each memory level is one request: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_valid_i`, and exactly one valid response is consumed per level.
- R10: When the indirect flag is still set after `MAX_DEPTH` fetches, `err_o` pulses for one cycle, `done_o` does not assert, and the block returns to idle.
- R11: `start_i` is ignored while a resolution is in progress. It neither changes the result nor queues a second one.
- R12: After reset the block is idle with `busy_o`, `done_o`, `err_o` and `mem_req_o` low. `done_o` and `err_o` are single-cycle pulses and never assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Accept `insn_i` when idle |
| insn_i | input | 36 | Instruction word |
| busy_o | output | 1 | Resolution in progress |
| rf_addr_o | output | 4 | Register file read index |
| rf_data_i | input | 36 | Register file read data (combinational) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 18 | Memory read address |
| mem_rdata_i | input | 36 | Memory read data |
| mem_valid_i | input | 1 | Memory read data valid |
| done_o | output | 1 | Result valid pulse |
| ea_o | output | 18 | Effective address |
| word_o | output | 36 | Rewritten instruction word |
| err_o | output | 1 | Depth-limit abort pulse |

## Verification
The embedded assertions check these rules on every cycle:
- a pending memory request holds its address until valid;
- no memory request targets the register window;
- done and error are exclusive one-cycle pulses;
- the rewritten word always has a zero middle area and carries `ea_o`.

Only the bench scenarios can show that the addresses themselves are right: index addition and wrap-around, multi-level chains that mix register and memory hops, the disregard of fetched operation fields, the exact fetch count at the depth limit, and a start pulse ignored mid-resolution.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int WORD_W = 36;
    localparam int ADDR_W = 18;
    localparam int OP_W   = 9;
    localparam int AC_W   = 4;
    localparam int XR_W   = 4;
    localparam int REG_N  = 1 << XR_W;
    localparam int GAP_W  = 1 + XR_W;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [AC_W-1:0]   ac;
        logic              ind;
        logic [XR_W-1:0]   xr;
        logic [ADDR_W-1:0] y;
    } insn_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CALC,
        S_REGRD,
        S_MEMRD,
        S_DONE,
        S_FAULT
    } state_t;
endpackage

// File: rtl/ea_word_decode.sv
module ea_word_decode
    import ea_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output insn_t             fld_o
);
    // R1: field placement follows the packed struct layout, MSB first
    always_comb fld_o = insn_t'(word_i);
endmodule

// File: rtl/ea_index_add.sv
module ea_index_add
    import ea_pkg::*;
(
    input  logic [ADDR_W-1:0] y_i,
    input  logic [XR_W-1:0]   xr_i,
    input  logic [WORD_W-1:0] reg_i,
    output logic [ADDR_W-1:0] ea_o
);
    // R3/R4: index 0 means no indexing; the sum wraps at 18 bits
    always_comb begin
        if (xr_i == '0) ea_o = y_i;
        else            ea_o = y_i + reg_i[ADDR_W-1:0];
    end
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
    import ea_pkg::*;
#(
    parameter int MAX_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] insn_i,
    output logic              busy_o,
    output logic [XR_W-1:0]   rf_addr_o,
    input  logic [WORD_W-1:0] rf_data_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_valid_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic [WORD_W-1:0] word_o,
    output logic              err_o
);
    localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);
    localparam logic [DEPTH_W-1:0] DEPTH_CAP = DEPTH_W'(MAX_DEPTH);
    localparam logic [ADDR_W-1:0]  REG_TOP   = ADDR_W'(REG_N);

    state_t            state_q, state_d;
    logic [OP_W-1:0]   op_q;
    logic [AC_W-1:0]   ac_q;
    logic              ind_q;
    logic [XR_W-1:0]   xr_q;
    logic [ADDR_W-1:0] y_q;
    logic [ADDR_W-1:0] ea_q;
    logic [DEPTH_W-1:0] depth_q;

    logic [WORD_W-1:0] src_word;
    insn_t             src_fld;
    logic [ADDR_W-1:0] ea_calc;

    always_comb begin
        unique case (state_q)
            S_IDLE:  src_word = insn_i;
            S_REGRD: src_word = rf_data_i;
            default: src_word = mem_rdata_i;
        endcase
    end

    ea_word_decode u_dec (
        .word_i (src_word),
        .fld_o  (src_fld)
    );

    ea_index_add u_add (
        .y_i   (y_q),
        .xr_i  (xr_q),
        .reg_i (rf_data_i),
        .ea_o  (ea_calc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_CALC;          // R11: start seen only here
            S_CALC: begin
                if (!ind_q)                  state_d = S_DONE;
                else if (depth_q == DEPTH_CAP) state_d = S_FAULT; // R10
                else if (ea_calc < REG_TOP)  state_d = S_REGRD;   // R6
                else                         state_d = S_MEMRD;
            end
            S_REGRD: state_d = S_CALC;
            S_MEMRD: if (mem_valid_i) state_d = S_CALC;
            S_DONE:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            ac_q    <= '0;
            ind_q   <= 1'b0;
            xr_q    <= '0;
            y_q     <= '0;
            ea_q    <= '0;
            depth_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    op_q    <= src_fld.op;   // R8: captured once
                    ac_q    <= src_fld.ac;
                    ind_q   <= src_fld.ind;
                    xr_q    <= src_fld.xr;
                    y_q     <= src_fld.y;
                    depth_q <= '0;
                end
                S_CALC: begin
                    ea_q <= ea_calc;
                    if (ind_q && depth_q != DEPTH_CAP) depth_q <= depth_q + 1'b1;
                end
                S_REGRD: begin               // R5/R6
                    ind_q <= src_fld.ind;
                    xr_q  <= src_fld.xr;
                    y_q   <= src_fld.y;
                end
                S_MEMRD: if (mem_valid_i) begin // R5/R9
                    ind_q <= src_fld.ind;
                    xr_q  <= src_fld.xr;
                    y_q   <= src_fld.y;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != S_IDLE);
        rf_addr_o  = (state_q == S_REGRD) ? ea_q[XR_W-1:0] : xr_q;
        mem_req_o  = (state_q == S_MEMRD);
        mem_addr_o = ea_q;
        done_o     = (state_q == S_DONE);
        err_o      = (state_q == S_FAULT);
        ea_o       = ea_q;
        word_o     = {op_q, ac_q, {GAP_W{1'b0}}, ea_q}; // R7
    end

    // assertions
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    p_reg_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o >= REG_TOP));

    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!err_o && !busy_o));

    p_word_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (word_o[ADDR_W+GAP_W-1:ADDR_W] == '0 && word_o[ADDR_W-1:0] == ea_o));
endmodule

// File: tb/tb_ea_resolver.sv
module tb_ea_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    typedef struct packed {
        logic [35:0] insn;
        logic [17:0] ea;
        logic        err;
        logic [3:0]  nrd;
    } vec_t;

    function automatic logic [35:0] mkw(input logic [8:0] op, input logic [3:0] ac,
                                        input logic i, input logic [3:0] x, input logic [17:0] y);
        return {op, ac, i, x, y};
    endfunction

    // R2..R10 vectors: instruction, expected address, expected abort, memory reads
    localparam vec_t VECS [0:NV-1] = '{
        '{mkw(9'o257, 4'd5, 1'b0, 4'd0, 18'h01234), 18'h01234, 1'b0, 4'd0}, // R2
        '{mkw(9'o257, 4'd7, 1'b0, 4'd1, 18'h00100), 18'h00110, 1'b0, 4'd0}, // R3
        '{mkw(9'o101, 4'd2, 1'b0, 4'd0, 18'h00200), 18'h00200, 1'b0, 4'd0}, // R4
        '{mkw(9'o257, 4'd7, 1'b0, 4'd2, 18'h00005), 18'h00004, 1'b0, 4'd0}, // R3 wrap
        '{mkw(9'o033, 4'd1, 1'b1, 4'd0, 18'h00040), 18'h00077, 1'b0, 4'd1}, // R5 R8
        '{mkw(9'o257, 4'd7, 1'b1, 4'd1, 18'h00030), 18'h00077, 1'b0, 4'd1}, // R5
        '{mkw(9'o257, 4'd7, 1'b1, 4'd0, 18'h00050), 18'h00123, 1'b0, 4'd2}, // R5
        '{mkw(9'o257, 4'd3, 1'b1, 4'd0, 18'h00003), 18'h00030, 1'b0, 4'd0}, // R6
        '{mkw(9'o257, 4'd7, 1'b1, 4'd0, 18'h00004), 18'h00123, 1'b0, 4'd2}, // R6
        '{mkw(9'o257, 4'd7, 1'b1, 4'd0, 18'h00090), 18'h00030, 1'b0, 4'd1}, // R6
        '{mkw(9'o257, 4'd7, 1'b1, 4'd0, 18'h00080), 18'h00000, 1'b1, 4'd8}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [35:0] insn = '0;
    logic        busy, mem_req, done, err;
    logic [3:0]  rf_addr;
    logic [35:0] rf_data, mem_rdata, word;
    logic [17:0] mem_addr, ea;
    logic        mem_valid = 1'b0;
    logic [1:0]  dly = '0;
    int          rd_cnt = 0;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    logic [35:0] regs [16];
    logic [35:0] mem  [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_data = regs[rf_addr];

    ea_resolver dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .insn_i(insn),
        .busy_o(busy), .rf_addr_o(rf_addr), .rf_data_i(rf_data),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .mem_valid_i(mem_valid), .done_o(done), .ea_o(ea), .word_o(word), .err_o(err)
    );

    // memory responder: valid two cycles after a request is seen
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_valid <= 1'b0;
            dly       <= '0;
        end else if (mem_valid) begin
            mem_valid <= 1'b0;
            dly       <= '0;
            rd_cnt    <= rd_cnt + 1;
        end else if (mem_req) begin
            if (dly == 2'd1) begin
                mem_valid <= 1'b1;
                mem_rdata <= mem[mem_addr[7:0]];
            end else dly <= dly + 1'b1;
        end
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // start one resolution; wait for done/err at a negedge
    task automatic run(input logic [35:0] w, output logic d, output logic e, output int nrd);
        int base;
        base = rd_cnt;
        @(negedge clk);
        insn  = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        d = 1'b0; e = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (done || err) break;
            @(negedge clk);
        end
        d = done; e = err;
        nrd = rd_cnt - base;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
                finish_run();
            end
        end
    end

    initial begin
        logic d, e;
        int   nrd;
        for (int i = 0; i < 16; i++) regs[i] = '0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        regs[0] = {18'h00000, 18'h00100};
        regs[1] = {18'h12345, 18'h00010};
        regs[2] = {18'h00001, 18'h3FFFF};
        regs[3] = mkw(9'o000, 4'd0, 1'b0, 4'd1, 18'h00020);
        regs[4] = mkw(9'o000, 4'd0, 1'b1, 4'd0, 18'h00050);
        mem[8'h40] = mkw(9'h1FF, 4'hF, 1'b0, 4'd0, 18'h00077);
        mem[8'h50] = mkw(9'o000, 4'd0, 1'b1, 4'd1, 18'h00060);
        mem[8'h70] = mkw(9'o000, 4'd0, 1'b0, 4'd0, 18'h00123);
        mem[8'h80] = mkw(9'o000, 4'd0, 1'b1, 4'd0, 18'h00080);
        mem[8'h90] = mkw(9'o000, 4'd0, 1'b1, 4'd0, 18'h00003);

        repeat (3) @(negedge clk);
        check("R12 reset busy", 64'(busy), 64'(0));
        check("R12 reset done", 64'(done), 64'(0));
        check("R12 reset err",  64'(err),  64'(0));
        check("R12 reset req",  64'(mem_req), 64'(0));
        rst_n = 1'b1;

        // vector table
        for (int v = 0; v < NV; v++) begin
            run(VECS[v].insn, d, e, nrd);
            check($sformatf("R10 v%0d abort", v), 64'(e), 64'(VECS[v].err));
            check($sformatf("R12 v%0d done", v),  64'(d), 64'(!VECS[v].err));
            check($sformatf("R9 v%0d reads", v),  64'(nrd), 64'(VECS[v].nrd));
            if (!VECS[v].err) begin
                check($sformatf("R5 v%0d ea", v), 64'(ea), 64'(VECS[v].ea));
                check($sformatf("R7 R8 v%0d word", v), 64'(word),
                      64'({VECS[v].insn[35:23], 5'b0, VECS[v].ea}));
            end
            @(negedge clk);
            check($sformatf("R12 v%0d pulse", v), 64'({done, err, busy}), 64'(0));
        end

        // R11: a second start during a resolution is ignored
        begin
            logic [35:0] a;
            logic [35:0] b;
            int          extra;
            a = mkw(9'o257, 4'd7, 1'b1, 4'd0, 18'h00050);
            b = mkw(9'o111, 4'd1, 1'b0, 4'd0, 18'h01234);
            @(negedge clk);
            insn = a; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            insn = b; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 300; k++) begin
                if (done || err) break;
                @(negedge clk);
            end
            check("R11 ea kept", 64'(ea), 64'(18'h00123));
            check("R11 word kept", 64'(word), 64'({a[35:23], 5'b0, 18'h00123}));
            extra = 0;
            repeat (12) begin
                @(negedge clk);
                if (done) extra++;
            end
            check("R11 no queued result", 64'(extra), 64'(0));
        end

        finish_run();
    end
endmodule